// File: doc/BRIEF.md
# Recoverable Soft-Reset Sequencer

This block lets a small 32-bit core take a soft reset without losing its place. An active-low reset request pin is synchronised and must be seen low for a minimum number of consecutive clock cycles before it counts. Once the request is accepted, the sequencer holds back retirement of later instructions. It lets the one instruction at the retirement boundary finish or fault, and waits until the completed-store queue is empty. At that point it captures the restart address, the machine state and the restart-safety flag.

The vector step waits until the request pin has been released. In that cycle the sequencer writes both save/restore registers and the machine state register, pulses an instruction-cache disable, and redirects fetch to one of two reset vectors, chosen by the saved interrupt-prefix bit. A machine check outranks the soft reset. A machine check that arrives while the sequence is in flight abandons it and raises a sticky non-recoverable flag. The block's own synchronous reset plays the role of hard reset and clears everything.

Bit positions below use vector indices (index 31 is the MSB). The interrupt-prefix bit is index 6, machine-check enable is index 12, interrupt-little-endian is index 16, instruction and data translation are indices 5 and 4, the recoverable bit is index 1 and little-endian mode is index 0.

Top module: `softrst_seq`

## Requirements
- R1: A request is accepted only after the synchronised pin has been low for 2 consecutive cycles. A single-cycle low pulse leaves `stall_o` at 0.
- R2: `stall_o` rises after acceptance and stays high through the vector cycle. The drain does not finish until `retire_i` has been seen at least once.
- R3: The drain does not finish while `sq_empty_i` is 0.
- R4: Vectoring (`redirect_o`) happens only once the pin is high again. The target is 0x0000_0100 when saved MSR index 6 is 0, and 0xFFF0_0100 when it is 1.
- R5: SRR0 gets the value of `next_ea_i` in the cycle the drain finishes.
- R6: SRR1 indices 31:16 are 0, and indices 15:0 are copied from the captured MSR.
- R7: When `corrupt_i` is 1 at drain completion, SRR1 index 1 is written as 0.
- R8: In the new MSR, indices 6, 12 and 16 keep their prior values and index 0 takes the prior index 16. Every other bit, including 5 and 4, is 0.
- R9: While `mchk_i` is 1, a pending request is not accepted. `rst_n` low clears every state and flag.
- R10: A machine check during drain or while waiting for release abandons the sequence. There is no write and no redirect, `stall_o` drops, and `unrec_o` rises and stays high until `rst_n`.
- R11: All three write enables, `redirect_o` and `icache_dis_o` pulse together for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| srst_pin_n | input | 1 | Asynchronous active-low soft-reset request |
| mchk_i | input | 1 | Machine check pending |
| retire_i | input | 1 | Boundary instruction retired or faulted |
| next_ea_i | input | 32 | Address of the next instruction to retire |
| sq_empty_i | input | 1 | Completed-store queue empty |
| corrupt_i | input | 1 | State cannot be reliably restarted |
| msr_i | input | 32 | Current machine state register |
| stall_o | output | 1 | Block retirement of later instructions |
| srr0_we_o | output | 1 | SRR0 write enable |
| srr0_o | output | 32 | SRR0 write value |
| srr1_we_o | output | 1 | SRR1 write enable |
| srr1_o | output | 32 | SRR1 write value |
| msr_we_o | output | 1 | MSR write enable |
| msr_o | output | 32 | New MSR value |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Reset vector address |
| icache_dis_o | output | 1 | Instruction-cache disable strobe |
| unrec_o | output | 1 | Sticky non-recoverable soft reset |

## Verification
The bench sends one-cycle pin glitches, which a filter that acts on a single sample would wrongly accept. It holds the store queue non-empty and withholds the retirement handshake to catch a drain that finishes early, which would show up as an early redirect. It keeps the pin low after the drain to catch vectoring before release. It walks both interrupt-prefix settings and the corrupted-state flag, so a wrong vector or a set recoverable bit is caught. Machine checks are raised both before acceptance and mid-sequence, which exposes priority errors and a non-sticky abandon flag.

// File: rtl/srst_pkg.sv
// Package: shared constants for the soft-reset sequencer.
// Assumes a 32-bit machine state register with vector index 31 as MSB.
package srst_pkg;
    localparam int XLEN  = 32;
    localparam int HALF  = XLEN / 2;
    localparam int B_LE  = 0;
    localparam int B_RI  = 1;
    localparam int B_DR  = 4;
    localparam int B_IR  = 5;
    localparam int B_IP  = 6;
    localparam int B_ME  = 12;
    localparam int B_ILE = 16;
    localparam logic [XLEN-1:0] VEC_LO = 32'h0000_0100;
    localparam logic [XLEN-1:0] VEC_HI = 32'hFFF0_0100;

    typedef enum logic [2:0] {
        S_IDLE, S_DRAIN, S_WREL, S_VEC, S_ABAN
    } seq_state_t;
endpackage

// File: rtl/srst_qualify.sv
// Module: srst_qualify
// Synchronises the asynchronous active-low request pin and asserts
// qual_o once the synchronised level has been low for MIN_LOW cycles.
// Assumes MIN_LOW >= 1 and SYNC_STAGES >= 2.
module srst_qualify #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_lo_o,
    output logic qual_o
);
    localparam int CW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
    localparam logic [CW-1:0] CMAX = CW'(MIN_LOW - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;

    // Synchroniser chain, idle-high.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q[g] <= 1'b1;
                else if (g == 0)
                    sync_q[g] <= pin_n;
                else
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign pin_lo_o = ~sync_q[SYNC_STAGES-1];

    // Count earlier consecutive low cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_lo_o)
            cnt_q <= '0;
        else if (cnt_q != CMAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign qual_o = pin_lo_o && (cnt_q == CMAX);
endmodule

// File: rtl/srst_ctrl.sv
// Module: srst_ctrl
// Sequencing state machine: accept, drain to a precise point, wait for
// pin release, vector. A machine check abandons the sequence.
// Assumes the core holds later retirements while stall_o is high.
module srst_ctrl
    import srst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic pin_lo_i,
    input  logic mchk_i,
    input  logic retire_i,
    input  logic sq_empty_i,
    output logic cap_o,
    output logic stall_o,
    output logic vec_o,
    output logic unrec_o
);
    seq_state_t state_q, state_d;
    logic bnd_q;
    logic unrec_q;

    // Drain done: boundary instruction finished and store queue empty.
    always_comb begin
        cap_o = (state_q == S_DRAIN) && !mchk_i && (bnd_q || retire_i) && sq_empty_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (qual_i && !mchk_i) state_d = S_DRAIN;
            S_DRAIN: if (mchk_i) state_d = S_ABAN;
                     else if (cap_o) state_d = S_WREL;
            S_WREL:  if (mchk_i) state_d = S_ABAN;
                     else if (!pin_lo_i) state_d = S_VEC;
            S_VEC:   state_d = S_IDLE;
            S_ABAN:  if (!pin_lo_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State, boundary flag and sticky abandon flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bnd_q   <= 1'b0;
            unrec_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != S_DRAIN)
                bnd_q <= 1'b0;
            else if (retire_i)
                bnd_q <= 1'b1;
            if (state_d == S_ABAN && state_q != S_ABAN)
                unrec_q <= 1'b1;
        end
    end

    assign stall_o = (state_q == S_DRAIN) || (state_q == S_WREL) || (state_q == S_VEC);
    assign vec_o   = (state_q == S_VEC);
    assign unrec_o = unrec_q;
endmodule

// File: rtl/srst_ctx.sv
// Module: srst_ctx
// Captures restart context at drain completion and forms the SRR1
// value, the new MSR and the reset vector from it.
// Assumes cap_i is a single-cycle strobe.
module srst_ctx
    import srst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic [XLEN-1:0] ea_i,
    input  logic [XLEN-1:0] msr_i,
    input  logic            corrupt_i,
    output logic [XLEN-1:0] srr0_o,
    output logic [XLEN-1:0] srr1_o,
    output logic [XLEN-1:0] msr_o,
    output logic [XLEN-1:0] pc_o
);
    logic [XLEN-1:0] ea_q, msr_q;
    logic            corr_q;

    // Context capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            msr_q  <= '0;
            corr_q <= 1'b0;
        end else if (cap_i) begin
            ea_q   <= ea_i;
            msr_q  <= msr_i;
            corr_q <= corrupt_i;
        end
    end

    // Save/restore image of the old machine state.
    always_comb begin
        srr1_o = {{HALF{1'b0}}, msr_q[HALF-1:0]};
        if (corr_q)
            srr1_o[B_RI] = 1'b0;
    end

    // New machine state: keep prefix, machine-check enable and ILE.
    always_comb begin
        msr_o        = '0;
        msr_o[B_IP]  = msr_q[B_IP];
        msr_o[B_ME]  = msr_q[B_ME];
        msr_o[B_ILE] = msr_q[B_ILE];
        msr_o[B_LE]  = msr_q[B_ILE];
    end

    assign srr0_o = ea_q;
    assign pc_o   = msr_q[B_IP] ? VEC_HI : VEC_LO;
endmodule

// File: rtl/softrst_seq.sv
// Module: softrst_seq (top)
// Recoverable soft-reset sequencer: qualifies the request pin, drains
// the pipeline, captures context and vectors after pin release.
// Assumes rst_n is the hard reset and therefore outranks everything.
module softrst_seq
    import srst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst_pin_n,
    input  logic            mchk_i,
    input  logic            retire_i,
    input  logic [XLEN-1:0] next_ea_i,
    input  logic            sq_empty_i,
    input  logic            corrupt_i,
    input  logic [XLEN-1:0] msr_i,
    output logic            stall_o,
    output logic            srr0_we_o,
    output logic [XLEN-1:0] srr0_o,
    output logic            srr1_we_o,
    output logic [XLEN-1:0] srr1_o,
    output logic            msr_we_o,
    output logic [XLEN-1:0] msr_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            icache_dis_o,
    output logic            unrec_o
);
    logic pin_lo, qual, cap, vec;

    srst_qualify #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) i_qual (
        .clk(clk), .rst_n(rst_n), .pin_n(srst_pin_n),
        .pin_lo_o(pin_lo), .qual_o(qual)
    );

    srst_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .qual_i(qual), .pin_lo_i(pin_lo),
        .mchk_i(mchk_i), .retire_i(retire_i), .sq_empty_i(sq_empty_i),
        .cap_o(cap), .stall_o(stall_o), .vec_o(vec), .unrec_o(unrec_o)
    );

    srst_ctx i_ctx (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .ea_i(next_ea_i),
        .msr_i(msr_i), .corrupt_i(corrupt_i),
        .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o), .pc_o(redirect_pc_o)
    );

    assign srr0_we_o    = vec;
    assign srr1_we_o    = vec;
    assign msr_we_o     = vec;
    assign redirect_o   = vec;
    assign icache_dis_o = vec;
endmodule

// File: rtl/softrst_seq_chk.sv
// Module: softrst_seq_chk
// Property checker bound into softrst_seq.
module softrst_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pin_lo,
    input logic        cap,
    input logic        mchk_i,
    input logic        sq_empty_i,
    input logic        stall_o,
    input logic        srr1_we_o,
    input logic [31:0] srr1_o,
    input logic        msr_we_o,
    input logic [31:0] msr_o,
    input logic        redirect_o,
    input logic [31:0] redirect_pc_o,
    input logic        icache_dis_o,
    input logic        unrec_o
);
    AST_TWO_LOW_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(pin_lo) && $past(pin_lo, 2)); // R1
    AST_DRAIN_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> sq_empty_i); // R3
    AST_VEC_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !pin_lo && stall_o); // R4
    AST_VEC_BY_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> redirect_pc_o == (msr_o[6] ? 32'hFFF0_0100 : 32'h0000_0100)); // R4
    AST_SRR1_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        srr1_we_o |-> srr1_o[31:16] == 16'h0); // R6
    AST_MSR_REAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we_o |-> msr_o[5:4] == 2'b00 && msr_o[0] == msr_o[16]); // R8
    AST_MCHK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_i && !stall_o |=> !stall_o); // R9
    AST_UNREC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unrec_o |=> unrec_o); // R10
    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o && !icache_dis_o); // R11
    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        icache_dis_o == redirect_o && msr_we_o == redirect_o); // R11
endmodule

bind softrst_seq softrst_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .pin_lo(pin_lo), .cap(cap), .mchk_i(mchk_i),
    .sq_empty_i(sq_empty_i), .stall_o(stall_o), .srr1_we_o(srr1_we_o),
    .srr1_o(srr1_o), .msr_we_o(msr_we_o), .msr_o(msr_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .icache_dis_o(icache_dis_o), .unrec_o(unrec_o)
);

// File: tb/test_softrst_seq.sv
module test_softrst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srst_pin_n = 1'b1;
    logic        mchk_i = 1'b0;
    logic        retire_i = 1'b0;
    logic [31:0] next_ea_i = '0;
    logic        sq_empty_i = 1'b1;
    logic        corrupt_i = 1'b0;
    logic [31:0] msr_i = '0;
    logic        stall_o, srr0_we_o, srr1_we_o, msr_we_o, redirect_o, icache_dis_o, unrec_o;
    logic [31:0] srr0_o, srr1_o, msr_o, redirect_pc_o;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    softrst_seq i_softrst_seq (.*);

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for stall_o to rise; returns 1 if it did.
    task automatic wait_stall(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (stall_o) seen = 1'b1;
        end
    endtask

    task automatic wait_redirect(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (redirect_o) seen = 1'b1;
        end
    endtask

    // Stimulus table: old MSR, restart EA, corrupt, expected vector, SRR1, new MSR.
    localparam int NV = 5;
    localparam logic [31:0] T_MSR [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0001_0032, 32'h0000_1042};
    localparam logic [31:0] T_EA  [NV] = '{32'h0000_2000, 32'h0000_3004, 32'hABCD_0010, 32'h1234_5678, 32'h8000_0FFC};
    localparam logic        T_COR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] T_PC  [NV] = '{32'h0000_0100, 32'hFFF0_0100, 32'hFFF0_0100, 32'h0000_0100, 32'hFFF0_0100};
    localparam logic [31:0] T_S1  [NV] = '{32'h0000_0000, 32'h0000_FFFF, 32'h0000_FFFD, 32'h0000_0032, 32'h0000_1040};
    localparam logic [31:0] T_NM  [NV] = '{32'h0000_0000, 32'h0001_1041, 32'h0001_1041, 32'h0001_0001, 32'h0000_1040};

    initial begin
        logic seen;
        // Reset state (R9).
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R9 reset stall", {31'b0, stall_o}, 32'h0);
        check("R9 reset redirect", {31'b0, redirect_o}, 32'h0);
        check("R9 reset unrec", {31'b0, unrec_o}, 32'h0);

        // Table walk: full sequences (R2 R4 R5 R6 R7 R8 R11).
        for (int v = 0; v < NV; v++) begin
            msr_i = T_MSR[v]; next_ea_i = T_EA[v]; corrupt_i = T_COR[v];
            sq_empty_i = 1'b0;
            srst_pin_n = 1'b0;
            wait_stall(seen);
            check("R2 stall raised", {31'b0, seen}, 32'h1);
            cyc(2);
            retire_i = 1'b1; cyc(1); retire_i = 1'b0;
            cyc(3);
            check("R3 no vector while store queue busy", {31'b0, redirect_o}, 32'h0);
            sq_empty_i = 1'b1;
            cyc(4);
            check("R4 held pin blocks vector", {31'b0, redirect_o}, 32'h0);
            srst_pin_n = 1'b1;
            wait_redirect(seen);
            check("R4 redirect seen", {31'b0, seen}, 32'h1);
            check("R4 vector", redirect_pc_o, T_PC[v]);
            check("R5 srr0", srr0_o, T_EA[v]);
            check("R6 R7 srr1", srr1_o, T_S1[v]);
            check("R8 new msr", msr_o, T_NM[v]);
            check("R11 strobes", {27'b0, srr0_we_o, srr1_we_o, msr_we_o, icache_dis_o, stall_o}, 32'h1F);
            cyc(1);
            check("R11 one-cycle pulse", {30'b0, redirect_o, icache_dis_o}, 32'h0);
            check("R2 stall released", {31'b0, stall_o}, 32'h0);
            cyc(4);
        end

        // R1: single-cycle glitches are ignored.
        for (int k = 0; k < 3; k++) begin
            srst_pin_n = 1'b0; cyc(1); srst_pin_n = 1'b1;
            cyc(3);
        end
        wait_stall(seen);
        check("R1 short pulse ignored", {31'b0, seen}, 32'h0);

        // R2: no retire handshake keeps the drain open.
        msr_i = 32'h0; next_ea_i = 32'h4000; corrupt_i = 1'b0;
        srst_pin_n = 1'b0;
        wait_stall(seen);
        srst_pin_n = 1'b1;
        cyc(8);
        check("R2 drain waits for retire", {30'b0, stall_o, redirect_o}, 32'h2);
        next_ea_i = 32'h4008;
        retire_i = 1'b1; cyc(1); retire_i = 1'b0;
        wait_redirect(seen);
        check("R2 vector after retire", {31'b0, seen}, 32'h1);
        check("R5 srr0 at drain end", srr0_o, 32'h4008);
        cyc(4);

        // R9: machine check outranks a pending request.
        mchk_i = 1'b1;
        srst_pin_n = 1'b0;
        cyc(6);
        check("R9 mchk blocks accept", {31'b0, stall_o}, 32'h0);
        mchk_i = 1'b0;
        wait_stall(seen);
        check("R9 accept after mchk clears", {31'b0, seen}, 32'h1);

        // R10: machine check mid-drain abandons the sequence.
        mchk_i = 1'b1; cyc(1); mchk_i = 1'b0;
        cyc(1);
        check("R10 unrec raised", {31'b0, unrec_o}, 32'h1);
        check("R10 stall dropped", {31'b0, stall_o}, 32'h0);
        retire_i = 1'b1; cyc(1); retire_i = 1'b0;
        srst_pin_n = 1'b1;
        wait_redirect(seen);
        check("R10 no vector after abandon", {31'b0, seen}, 32'h0);
        check("R10 unrec sticky", {31'b0, unrec_o}, 32'h1);
        rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(1);
        check("R9 hard reset clears unrec", {31'b0, unrec_o}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule